// File: doc/BRIEF.md
# Micro-op Dispatch Gate

This block sits between the instruction queue and the scheduler of an out-of-order core. Each cycle it looks at the oldest waiting instruction, which carries its micro-op count, the number of rename registers it needs in each register file and a mask of the scheduler buffers it occupies. It compares those needs against the free-entry counts reported by the reorder buffer, the rename tracker and the scheduler buffers, and decides how many micro-ops may go to the scheduler in this cycle.

All resources are checked and reserved when the first group of an instruction is sent. An instruction larger than the per-cycle dispatch width is then sent in width-sized groups on consecutive cycles, with no further checks. The input handshake completes only in the cycle that sends the last group, so no younger instruction can enter while an older one is still going out. In every cycle where the head instruction is held back, a saturating counter is bumped for each resource that blocked it: one for the reorder buffer, one per register file, and one for the scheduler buffers.

Top module: `dispatch_gate`

## Requirements
- R1: The first group of an instruction is sent only when `rob_free` is at least the instruction's total `in_uops`.
- R2: The first group is sent only when, for every register file i, the free count in `rf_free[i*RF_FREE_W +: RF_FREE_W]` is at least the need in `in_rf_need[i*RF_NEED_W +: RF_NEED_W]`.
- R3: The first group is sent only when every buffer i whose bit is set in `in_buf_use` has a nonzero count in `buf_free[i*BUF_W +: BUF_W]`; buffers whose bit is clear are not checked.
- R4: `disp_uops` never exceeds DISPATCH_WIDTH; each group carries min(remaining micro-ops, DISPATCH_WIDTH).
- R5: An instruction with more micro-ops than DISPATCH_WIDTH goes out over consecutive cycles; after its first group the availability inputs are ignored, and `alloc_valid` (with `alloc_rob`, `alloc_rf`, `alloc_buf` equal to the instruction's needs) is high only in the first-group cycle.
- R6: `in_ready` is high only in the cycle the last group of the instruction is sent; an instruction that fits in one group is accepted in the same cycle it passes the checks.
- R7: In a cycle where a new instruction is valid but not sent, `stall_rob_cnt` increments if the reorder-buffer check fails; it never changes in a cycle that dispatches.
- R8: In such a stall cycle, counter i of `stall_rf_cnt` increments exactly when register file i fails its check, so one cycle may count against several files.
- R9: In such a stall cycle, `stall_buf_cnt` increments when any used scheduler buffer is full.
- R10: Every stall counter is CTR_W bits wide and holds at its maximum value instead of wrapping.
- R11: Reset clears all stall counters and abandons any partly sent instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Head instruction present |
| in_ready | output | 1 | Head instruction consumed this cycle |
| in_uops | input | UOP_W | Micro-op count of the head instruction (1 or more) |
| in_rf_need | input | NUM_RF*RF_NEED_W | Rename registers needed per register file |
| in_buf_use | input | NUM_BUF | Scheduler buffers used by the instruction |
| rob_free | input | ROB_W | Free reorder-buffer entries |
| rf_free | input | NUM_RF*RF_FREE_W | Free rename registers per register file |
| buf_free | input | NUM_BUF*BUF_W | Free entries per scheduler buffer |
| disp_valid | output | 1 | A group of micro-ops is sent this cycle |
| disp_uops | output | UOP_W | Micro-ops in this group |
| alloc_valid | output | 1 | Reserve resources for the instruction now |
| alloc_rob | output | UOP_W | Reorder-buffer entries to reserve |
| alloc_rf | output | NUM_RF*RF_NEED_W | Rename registers to reserve per file |
| alloc_buf | output | NUM_BUF | Scheduler buffers to take one entry from |
| stall_rob_cnt | output | CTR_W | Stalls caused by the reorder buffer |
| stall_rf_cnt | output | NUM_RF*CTR_W | Stalls caused by each register file |
| stall_buf_cnt | output | CTR_W | Stalls caused by scheduler buffers |

## Verification
The assertions watch, on every cycle, that a reservation never happens while the reorder buffer, any register file or any used buffer is short, that a group never exceeds the width, that a partly sent instruction keeps dispatching, that an accepted instruction is dispatching, and that counters move by at most one and stay put when anything is sent. Only the bench scenarios show the exact group sizes of a long instruction, that the checks are ignored after its first group, that each counter is attributed to the right cause, the saturation value of a narrow counter, and that reset abandons a half-sent instruction.

// File: rtl/dispatch_gate_pkg.sv
package dispatch_gate_pkg;
  typedef enum logic {
    DG_IDLE = 1'b0,
    DG_CONT = 1'b1
  } dg_phase_e;
endpackage

// File: rtl/dg_avail_check.sv
module dg_avail_check #(
  parameter int UOP_W     = 4,
  parameter int ROB_W     = 6,
  parameter int NUM_RF    = 2,
  parameter int RF_NEED_W = 2,
  parameter int RF_FREE_W = 6,
  parameter int NUM_BUF   = 3,
  parameter int BUF_W     = 4
) (
  input  logic [UOP_W-1:0]            uops,
  input  logic [ROB_W-1:0]            rob_free,
  input  logic [NUM_RF*RF_NEED_W-1:0] rf_need,
  input  logic [NUM_RF*RF_FREE_W-1:0] rf_free,
  input  logic [NUM_BUF-1:0]          buf_use,
  input  logic [NUM_BUF*BUF_W-1:0]    buf_free,
  output logic                        rob_fail,
  output logic [NUM_RF-1:0]           rf_fail,
  output logic                        buf_fail,
  output logic                        all_ok
);
  localparam int ROB_CMP_W = (ROB_W > UOP_W) ? ROB_W : UOP_W;
  localparam int RF_CMP_W  = (RF_FREE_W > RF_NEED_W) ? RF_FREE_W : RF_NEED_W;

  logic [NUM_BUF-1:0] buf_full;

  assign rob_fail = ROB_CMP_W'(rob_free) < ROB_CMP_W'(uops);

  for (genvar gi = 0; gi < NUM_RF; gi++) begin : g_rf
    assign rf_fail[gi] = RF_CMP_W'(rf_free[gi*RF_FREE_W +: RF_FREE_W])
                       < RF_CMP_W'(rf_need[gi*RF_NEED_W +: RF_NEED_W]);
  end

  for (genvar gb = 0; gb < NUM_BUF; gb++) begin : g_buf
    assign buf_full[gb] = buf_use[gb] && (buf_free[gb*BUF_W +: BUF_W] == '0);
  end

  assign buf_fail = |buf_full;
  assign all_ok   = !rob_fail && !(|rf_fail) && !buf_fail;
endmodule

// File: rtl/dg_chunker.sv
module dg_chunker
  import dispatch_gate_pkg::*;
#(
  parameter int DISPATCH_WIDTH = 4,
  parameter int UOP_W          = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             ok,
  input  logic [UOP_W-1:0] uops,
  output logic             busy,
  output logic             disp_valid,
  output logic [UOP_W-1:0] disp_uops,
  output logic             last
);
  localparam logic [UOP_W-1:0] WIDTH_U = UOP_W'(DISPATCH_WIDTH);

  dg_phase_e        phase_q, phase_d;
  logic [UOP_W-1:0] rem_q, rem_d;
  logic [UOP_W-1:0] src;
  logic             st_en;

  assign busy = (phase_q == DG_CONT);
  assign src  = busy ? rem_q : uops;
  assign last = (src <= WIDTH_U);

  always_comb begin
    disp_valid = busy || (in_valid && ok);
    disp_uops  = disp_valid ? (last ? src : WIDTH_U) : '0;
    phase_d    = phase_q;
    rem_d      = rem_q;
    if (disp_valid) begin
      phase_d = last ? DG_IDLE : DG_CONT;
      rem_d   = last ? '0 : (src - WIDTH_U);
    end
  end

  assign st_en = disp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= DG_IDLE;
      rem_q   <= '0;
    end else if (st_en) begin
      phase_q <= phase_d;
      rem_q   <= rem_d;
    end
  end
endmodule

// File: rtl/dg_sat_ctr.sv
module dg_sat_ctr #(
  parameter int CTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CTR_W-1:0] cnt
);
  logic [CTR_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = inc && !(&cnt);
  assign cnt_d  = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate
  import dispatch_gate_pkg::*;
#(
  parameter int DISPATCH_WIDTH = 4,
  parameter int UOP_W          = 4,
  parameter int ROB_W          = 6,
  parameter int NUM_RF         = 2,
  parameter int RF_NEED_W      = 2,
  parameter int RF_FREE_W      = 6,
  parameter int NUM_BUF        = 3,
  parameter int BUF_W          = 4,
  parameter int CTR_W          = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [UOP_W-1:0]            in_uops,
  input  logic [NUM_RF*RF_NEED_W-1:0] in_rf_need,
  input  logic [NUM_BUF-1:0]          in_buf_use,
  input  logic [ROB_W-1:0]            rob_free,
  input  logic [NUM_RF*RF_FREE_W-1:0] rf_free,
  input  logic [NUM_BUF*BUF_W-1:0]    buf_free,
  output logic                        disp_valid,
  output logic [UOP_W-1:0]            disp_uops,
  output logic                        alloc_valid,
  output logic [UOP_W-1:0]            alloc_rob,
  output logic [NUM_RF*RF_NEED_W-1:0] alloc_rf,
  output logic [NUM_BUF-1:0]          alloc_buf,
  output logic [CTR_W-1:0]            stall_rob_cnt,
  output logic [NUM_RF*CTR_W-1:0]     stall_rf_cnt,
  output logic [CTR_W-1:0]            stall_buf_cnt
);
  logic              rob_fail, buf_fail, all_ok;
  logic [NUM_RF-1:0] rf_fail;
  logic              busy, last, stall_ev;

  dg_avail_check #(
    .UOP_W(UOP_W), .ROB_W(ROB_W), .NUM_RF(NUM_RF), .RF_NEED_W(RF_NEED_W),
    .RF_FREE_W(RF_FREE_W), .NUM_BUF(NUM_BUF), .BUF_W(BUF_W)
  ) u_avail (
    .uops(in_uops), .rob_free(rob_free), .rf_need(in_rf_need), .rf_free(rf_free),
    .buf_use(in_buf_use), .buf_free(buf_free), .rob_fail(rob_fail),
    .rf_fail(rf_fail), .buf_fail(buf_fail), .all_ok(all_ok)
  );

  dg_chunker #(
    .DISPATCH_WIDTH(DISPATCH_WIDTH), .UOP_W(UOP_W)
  ) u_chunk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ok(all_ok), .uops(in_uops),
    .busy(busy), .disp_valid(disp_valid), .disp_uops(disp_uops), .last(last)
  );

  assign in_ready    = disp_valid && last;
  assign alloc_valid = in_valid && all_ok && !busy;
  assign alloc_rob   = alloc_valid ? in_uops    : '0;
  assign alloc_rf    = alloc_valid ? in_rf_need : '0;
  assign alloc_buf   = alloc_valid ? in_buf_use : '0;
  assign stall_ev    = in_valid && !busy;

  dg_sat_ctr #(.CTR_W(CTR_W)) u_ctr_rob (
    .clk(clk), .rst_n(rst_n), .inc(stall_ev && rob_fail), .cnt(stall_rob_cnt)
  );

  for (genvar gi = 0; gi < NUM_RF; gi++) begin : g_rf_ctr
    dg_sat_ctr #(.CTR_W(CTR_W)) u_ctr_rf (
      .clk(clk), .rst_n(rst_n), .inc(stall_ev && rf_fail[gi]),
      .cnt(stall_rf_cnt[gi*CTR_W +: CTR_W])
    );
  end

  dg_sat_ctr #(.CTR_W(CTR_W)) u_ctr_buf (
    .clk(clk), .rst_n(rst_n), .inc(stall_ev && buf_fail), .cnt(stall_buf_cnt)
  );
endmodule

// File: rtl/dispatch_gate_chk.sv
module dispatch_gate_chk #(
  parameter int DISPATCH_WIDTH = 4,
  parameter int UOP_W          = 4,
  parameter int ROB_W          = 6,
  parameter int NUM_RF         = 2,
  parameter int RF_NEED_W      = 2,
  parameter int RF_FREE_W      = 6,
  parameter int NUM_BUF        = 3,
  parameter int BUF_W          = 4,
  parameter int CTR_W          = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        in_valid,
  input logic                        in_ready,
  input logic [UOP_W-1:0]            in_uops,
  input logic [NUM_RF*RF_NEED_W-1:0] in_rf_need,
  input logic [NUM_BUF-1:0]          in_buf_use,
  input logic [ROB_W-1:0]            rob_free,
  input logic [NUM_RF*RF_FREE_W-1:0] rf_free,
  input logic [NUM_BUF*BUF_W-1:0]    buf_free,
  input logic                        disp_valid,
  input logic [UOP_W-1:0]            disp_uops,
  input logic                        alloc_valid,
  input logic [CTR_W-1:0]            stall_rob_cnt,
  input logic [CTR_W-1:0]            stall_buf_cnt
);
  localparam int CW = (ROB_W > UOP_W ? ROB_W : UOP_W) + 1;
  localparam int FW = (RF_FREE_W > RF_NEED_W ? RF_FREE_W : RF_NEED_W) + 1;

  logic rf_ok_c, buf_ok_c;

  always_comb begin
    rf_ok_c = 1'b1;
    for (int i = 0; i < NUM_RF; i++)
      if (FW'(rf_free[i*RF_FREE_W +: RF_FREE_W]) < FW'(in_rf_need[i*RF_NEED_W +: RF_NEED_W]))
        rf_ok_c = 1'b0;
    buf_ok_c = 1'b1;
    for (int b = 0; b < NUM_BUF; b++)
      if (in_buf_use[b] && buf_free[b*BUF_W +: BUF_W] == '0)
        buf_ok_c = 1'b0;
  end

  AST_ROB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> (CW'(rob_free) >= CW'(in_uops)));  // R1
  AST_RF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> rf_ok_c);  // R2
  AST_BUF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> buf_ok_c);  // R3
  AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> (disp_uops != '0 && CW'(disp_uops) <= CW'(DISPATCH_WIDTH)));  // R4
  AST_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !in_ready) |=> disp_valid);  // R5
  AST_ACCEPT_SENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> disp_valid);  // R6
  AST_ROB_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> (stall_rob_cnt == $past(stall_rob_cnt)));  // R7
  AST_BUF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, stall_buf_cnt} == {1'b0, $past(stall_buf_cnt)}) ||
             ({1'b0, stall_buf_cnt} == {1'b0, $past(stall_buf_cnt)} + 1'b1));  // R10
  AST_ROB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, stall_rob_cnt} == {1'b0, $past(stall_rob_cnt)}) ||
             ({1'b0, stall_rob_cnt} == {1'b0, $past(stall_rob_cnt)} + 1'b1));  // R10
endmodule

bind dispatch_gate dispatch_gate_chk #(
  .DISPATCH_WIDTH(DISPATCH_WIDTH), .UOP_W(UOP_W), .ROB_W(ROB_W), .NUM_RF(NUM_RF),
  .RF_NEED_W(RF_NEED_W), .RF_FREE_W(RF_FREE_W), .NUM_BUF(NUM_BUF), .BUF_W(BUF_W),
  .CTR_W(CTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_uops(in_uops), .in_rf_need(in_rf_need), .in_buf_use(in_buf_use),
  .rob_free(rob_free), .rf_free(rf_free), .buf_free(buf_free),
  .disp_valid(disp_valid), .disp_uops(disp_uops), .alloc_valid(alloc_valid),
  .stall_rob_cnt(stall_rob_cnt), .stall_buf_cnt(stall_buf_cnt)
);

// File: tb/dispatch_gate_tb.sv
module dispatch_gate_tb;
  logic        clk, rst_n;
  logic        in_valid;
  logic [3:0]  in_uops;
  logic [3:0]  in_rf_need;
  logic [2:0]  in_buf_use;
  logic [5:0]  rob_free;
  logic [11:0] rf_free;
  logic [11:0] buf_free;
  logic        in_ready, disp_valid, alloc_valid;
  logic [3:0]  disp_uops, alloc_rob, alloc_rf;
  logic [2:0]  alloc_buf;
  logic [31:0] stall_rob_cnt, stall_buf_cnt;
  logic [63:0] stall_rf_cnt;
  logic        s_ready, s_dv, s_av;
  logic [3:0]  s_du, s_ar, s_arf;
  logic [2:0]  s_ab;
  logic [2:0]  s_rob, s_buf;
  logic [5:0]  s_rf;

  int checks = 0, fails = 0;
  int exp_rob = 0, exp_rf0 = 0, exp_rf1 = 0, exp_buf = 0;
  bit done = 0;

  dispatch_gate u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_uops(in_uops), .in_rf_need(in_rf_need), .in_buf_use(in_buf_use),
    .rob_free(rob_free), .rf_free(rf_free), .buf_free(buf_free),
    .disp_valid(disp_valid), .disp_uops(disp_uops), .alloc_valid(alloc_valid),
    .alloc_rob(alloc_rob), .alloc_rf(alloc_rf), .alloc_buf(alloc_buf),
    .stall_rob_cnt(stall_rob_cnt), .stall_rf_cnt(stall_rf_cnt),
    .stall_buf_cnt(stall_buf_cnt)
  );

  dispatch_gate #(.CTR_W(3)) u_sat (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(s_ready),
    .in_uops(in_uops), .in_rf_need(in_rf_need), .in_buf_use(in_buf_use),
    .rob_free(rob_free), .rf_free(rf_free), .buf_free(buf_free),
    .disp_valid(s_dv), .disp_uops(s_du), .alloc_valid(s_av),
    .alloc_rob(s_ar), .alloc_rf(s_arf), .alloc_buf(s_ab),
    .stall_rob_cnt(s_rob), .stall_rf_cnt(s_rf), .stall_buf_cnt(s_buf)
  );

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // stall mask bits: [0] reorder buffer, [1] register file 0, [2] register file 1, [3] buffers
  typedef struct packed {
    logic [3:0]  uops;
    logic [5:0]  rob;
    logic [3:0]  need;
    logic [11:0] rff;
    logic [2:0]  use_m;
    logic [11:0] bf;
    logic [3:0]  edisp;
    logic        erdy;
    logic [3:0]  est;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 6'd10, 4'b0001, {6'd5, 6'd5}, 3'b001, 12'h333, 4'd2, 1'b1, 4'b0000},
    '{4'd4, 6'd4,  4'b0110, {6'd1, 6'd2}, 3'b111, 12'h111, 4'd4, 1'b1, 4'b0000},
    '{4'd3, 6'd2,  4'b0001, {6'd5, 6'd5}, 3'b001, 12'h333, 4'd0, 1'b0, 4'b0001},
    '{4'd1, 6'd8,  4'b0010, {6'd5, 6'd1}, 3'b000, 12'h000, 4'd0, 1'b0, 4'b0010},
    '{4'd1, 6'd8,  4'b1101, {6'd0, 6'd1}, 3'b000, 12'h000, 4'd0, 1'b0, 4'b0100},
    '{4'd1, 6'd8,  4'b0000, {6'd0, 6'd0}, 3'b010, 12'h303, 4'd0, 1'b0, 4'b1000},
    '{4'd5, 6'd1,  4'b0101, {6'd0, 6'd0}, 3'b100, 12'h033, 4'd0, 1'b0, 4'b1111},
    '{4'd1, 6'd1,  4'b0000, {6'd0, 6'd0}, 3'b000, 12'h000, 4'd1, 1'b1, 4'b0000},
    '{4'd4, 6'd3,  4'b0000, {6'd0, 6'd0}, 3'b000, 12'h000, 4'd0, 1'b0, 4'b0001}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ctrs(input string req);
    chk({req, " rob counter"}, 64'(stall_rob_cnt), 64'(exp_rob));
    chk({req, " rf0 counter"}, 64'(stall_rf_cnt[31:0]), 64'(exp_rf0));
    chk({req, " rf1 counter"}, 64'(stall_rf_cnt[63:32]), 64'(exp_rf1));
    chk({req, " buf counter"}, 64'(stall_buf_cnt), 64'(exp_buf));
  endtask

  task automatic drive_ok(input logic [3:0] u);
    in_valid = 1'b1; in_uops = u; in_rf_need = 4'b0000; rf_free = '0;
    in_buf_use = 3'b001; buf_free = 12'h333; rob_free = 6'd20;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_uops = 4'd1; in_rf_need = '0;
    in_buf_use = '0; rob_free = '0; rf_free = '0; buf_free = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R11: reset state
    chk_ctrs("R11 reset");
    chk("R11 idle no dispatch", 64'(disp_valid), 64'd0);

    // Table walk: single-cycle decisions (R1 R2 R3 R4 R6 R7 R8 R9)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      in_valid = 1'b1; in_uops = VECS[v].uops; rob_free = VECS[v].rob;
      in_rf_need = VECS[v].need; rf_free = VECS[v].rff;
      in_buf_use = VECS[v].use_m; buf_free = VECS[v].bf;
      #1;
      chk("R1/R2/R3 disp_uops", 64'(disp_uops), 64'(VECS[v].edisp));
      chk("R6 in_ready", 64'(in_ready), 64'(VECS[v].erdy));
      chk("R5 alloc_valid", 64'(alloc_valid), 64'(VECS[v].est == 4'b0000));
      if (VECS[v].est == 4'b0000) begin
        chk("R5 alloc_rob", 64'(alloc_rob), 64'(VECS[v].uops));
        chk("R5 alloc_rf", 64'(alloc_rf), 64'(VECS[v].need));
        chk("R5 alloc_buf", 64'(alloc_buf), 64'(VECS[v].use_m));
      end
      if (VECS[v].est[0]) exp_rob++;
      if (VECS[v].est[1]) exp_rf0++;
      if (VECS[v].est[2]) exp_rf1++;
      if (VECS[v].est[3]) exp_buf++;
      @(posedge clk); #1;
      chk_ctrs("R7/R8/R9 table");
    end

    // R5 R4 R6: ten micro-ops split 4,4,2; checks ignored after first group
    @(negedge clk); drive_ok(4'd10); #1;
    chk("R4 group1 size", 64'(disp_uops), 64'd4);
    chk("R6 group1 not ready", 64'(in_ready), 64'd0);
    chk("R5 group1 alloc", 64'(alloc_valid), 64'd1);
    chk("R5 group1 alloc_rob", 64'(alloc_rob), 64'd10);
    @(negedge clk); rob_free = 6'd0; buf_free = 12'h000; #1;
    chk("R5 group2 sent despite no room", 64'(disp_valid), 64'd1);
    chk("R4 group2 size", 64'(disp_uops), 64'd4);
    chk("R6 group2 not ready", 64'(in_ready), 64'd0);
    chk("R5 group2 no alloc", 64'(alloc_valid), 64'd0);
    @(negedge clk); #1;
    chk("R4 group3 size", 64'(disp_uops), 64'd2);
    chk("R6 group3 ready", 64'(in_ready), 64'd1);
    @(posedge clk); #1;
    chk_ctrs("R7 no stall counted mid-instruction");
    @(negedge clk); in_valid = 1'b0; #1;
    chk("R6 idle after last group", 64'(disp_valid), 64'd0);

    // R5 R6: exactly two full groups
    @(negedge clk); drive_ok(4'd8); #1;
    chk("R6 eight uops first not ready", 64'(in_ready), 64'd0);
    @(negedge clk); #1;
    chk("R4 eight uops second group", 64'(disp_uops), 64'd4);
    chk("R6 eight uops second ready", 64'(in_ready), 64'd1);

    // R10: hold a reorder-buffer stall long enough to saturate the narrow counter
    @(negedge clk); drive_ok(4'd3); rob_free = 6'd0;
    repeat (10) begin
      @(posedge clk); exp_rob++;
      @(negedge clk);
    end
    #1;
    chk("R7 wide counter keeps counting", 64'(stall_rob_cnt), 64'(exp_rob));
    chk("R10 narrow counter saturated", 64'(s_rob), 64'd7);

    // R11: reset mid-instruction abandons it
    @(negedge clk); drive_ok(4'd10);
    @(negedge clk); rst_n = 1'b0;
    #1;
    exp_rob = 0; exp_rf0 = 0; exp_rf1 = 0; exp_buf = 0;
    chk_ctrs("R11 counters cleared");
    @(negedge clk); rst_n = 1'b1; drive_ok(4'd2); #1;
    chk("R11 fresh instruction accepted", 64'(in_ready), 64'd1);
    chk("R11 fresh group size", 64'(disp_uops), 64'd2);
    @(negedge clk); in_valid = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule